// File: doc/BRIEF.md
# Serial Voltage-ID Command Receiver

This block listens on a two-wire serial bus that carries voltage-identification commands. It uses the SMBus send-byte format. The block samples the bus clock and data with the system clock. It detects start and stop conditions and checks an address byte. That byte holds a fixed three-bit prefix, a reserved bit, three rail-select bits and a write bit. When the address is accepted, the block pulls the data line low through an open-drain enable to acknowledge. It then captures one data byte, which holds a power-save hint and a seven-bit VID code.

A single command can update several rail registers at once, because each select bit names one rail. Captured values are held back until the stop condition arrives. At that point every selected rail register loads the new values, and a per-rail update strobe pulses for one clock. An address with the wrong prefix, a read request, or a start or stop that arrives in the middle of a byte leaves the rail registers untouched.

Top module: `svid_rx`

## Requirements
- R1: After reset, every rail's VID output equals the BOOT_VID parameter, every power-save output is 1, `update_o` is 0 and `sda_oe` is 0.
- R2: Bytes arrive MSB first. In the address byte, the first seven bits are the address and the eighth is the read/write flag. The address is accepted when address bits 6:4 equal 3'b110 and the flag is 0. Address bit 3 is reserved and does not affect acceptance. An accepted address is acknowledged: `sda_oe` is 1 while the ninth clock is high.
- R3: An address whose bits 6:4 differ from 3'b110 gets no acknowledge. The following data byte also gets no acknowledge, and the rail outputs and `update_o` do not change.
- R4: An address with the read/write flag at 1 gets no acknowledge and the transaction is discarded, with no rail change.
- R5: `sda_oe` rises only after the clock falls at the end of the eighth bit. It stays 1 through the high phase of the ninth clock and is released after that clock falls. During every data and address bit, `sda_oe` is 0.
- R6: Address bit 0 selects rail 0 (northbridge), bit 1 selects rail 1 (core 0) and bit 2 selects rail 2 (core 1). Any combination may be set, and every selected rail receives the data byte. Rail i occupies `rail_vid_o[7*i+6:7*i]` and `rail_psi_o[i]`.
- R7: After an accepted address, the data byte is acknowledged. Data bit 7 becomes the rail's power-save bit (0 means power saving is allowed). Data bits 6:0 become the rail's VID.
- R8: Rail outputs change only at the stop condition. The new values and a one-clock `update_o` pulse carrying the rail-select mask appear on the third rising clock edge after the data line rises for the stop. Outputs are unchanged at all other times.
- R9: A stop or start that arrives before a data byte has been acknowledged aborts the transaction without any rail change. A repeated start after the data acknowledge discards the pending values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock, asynchronous |
| sda_i | input | 1 | Bus data as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| rail_vid_o | output | 21 | Packed VID per rail, rail i at bits 7*i+6:7*i |
| rail_psi_o | output | 3 | Power-save bit per rail |
| update_o | output | 3 | One-clock strobe per rail on commit |

## Verification
The assertions check three things on every clock. First, the acknowledge enable rises only after a bus clock fall and is never released while the bus clock is high. Second, an update strobe follows a detected stop and lasts a single cycle. Third, rail values never move without a strobe. The scenarios in the bench cover address decoding and the rest of the behaviour. They include the prefix check, the ignored reserved bit, the read flag, multi-rail selection, the exact commit cycle, and aborts caused by mid-byte stops and starts or by a repeated start. The bench's reference model compares every rail output on every clock.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int RAILS = 3;
  localparam int VID_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_HOLD, ST_SKIP
  } fr_state_t;

  // address byte layout: [7:5] prefix, [4] reserved, [3:1] rail select, [0] rd/wr
  function automatic logic addr_ok(input logic [7:0] b, input logic [2:0] prefix);
    return (b[7:5] == prefix) && !b[0];
  endfunction

  function automatic logic [RAILS-1:0] rail_sel(input logic [7:0] b);
    return b[3:1];
  endfunction
endpackage

// File: rtl/svid_sync.sv
module svid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/svid_frame.sv
module svid_frame
  import svid_pkg::*;
#(
  parameter logic [2:0] PREFIX = 3'b110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             scl_rise,
  input  logic             scl_fall,
  output logic             sda_oe,
  output logic             commit,
  output logic [RAILS-1:0] sel_mask,
  output logic [7:0]       data_byte
);
  fr_state_t  state;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic       ack_on;
  logic [7:0] byte_nxt;

  assign byte_nxt = {shreg[6:0], sda_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ack_on    <= 1'b0;
      sel_mask  <= '0;
      data_byte <= '0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      ack_on <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      ack_on <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_DATA: if (scl_rise) begin
          shreg  <= byte_nxt;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            if (state == ST_DATA) begin
              data_byte <= byte_nxt;
              state     <= ST_DACK;
            end else if (addr_ok(byte_nxt, PREFIX)) begin
              sel_mask <= rail_sel(byte_nxt);
              state    <= ST_AACK;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_AACK, ST_DACK: if (scl_fall) begin
          if (!ack_on) ack_on <= 1'b1;
          else begin
            ack_on <= 1'b0;
            bitcnt <= '0;
            state  <= (state == ST_AACK) ? ST_DATA : ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = ack_on;
  assign commit = (state == ST_HOLD) && stop_evt;

  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall)); // R5
  AST_ACK_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && scl_s) |=> sda_oe); // R5
endmodule

// File: rtl/svid_rail_bank.sv
module svid_rail_bank
  import svid_pkg::*;
#(
  parameter logic [VID_W-1:0] BOOT_VID = 7'h2A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [RAILS-1:0]       sel_mask,
  input  logic [7:0]             data_byte,
  output logic [RAILS*VID_W-1:0] vid_o,
  output logic [RAILS-1:0]       psi_o,
  output logic [RAILS-1:0]       upd_o
);
  for (genvar i = 0; i < RAILS; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vid_o[i*VID_W +: VID_W] <= BOOT_VID;
        psi_o[i]                <= 1'b1;
        upd_o[i]                <= 1'b0;
      end else begin
        upd_o[i] <= commit & sel_mask[i];
        if (commit && sel_mask[i]) begin
          vid_o[i*VID_W +: VID_W] <= data_byte[VID_W-1:0];
          psi_o[i]                <= data_byte[7];
        end
      end
    end
  end

  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |=> (upd_o == '0)); // R8
  AST_RAIL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o == '0) |-> ($stable(vid_o) && $stable(psi_o))); // R8
endmodule

// File: rtl/svid_rx.sv
module svid_rx
  import svid_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [2:0]        ADDR_PREFIX = 3'b110,
  parameter logic [VID_W-1:0]  BOOT_VID    = 7'h2A
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  output logic [RAILS*VID_W-1:0] rail_vid_o,
  output logic [RAILS-1:0]       rail_psi_o,
  output logic [RAILS-1:0]       update_o
);
  logic scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic commit;
  logic [RAILS-1:0] sel_mask;
  logic [7:0] data_byte;

  svid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  svid_frame #(.PREFIX(ADDR_PREFIX)) u_frame (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_oe(sda_oe), .commit(commit),
    .sel_mask(sel_mask), .data_byte(data_byte));

  svid_rail_bank #(.BOOT_VID(BOOT_VID)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel_mask(sel_mask),
    .data_byte(data_byte), .vid_o(rail_vid_o), .psi_o(rail_psi_o),
    .upd_o(update_o));

  AST_UPD_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (|update_o) |-> $past(stop_evt)); // R8
  AST_NO_ACK_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> !sda_oe); // R9
endmodule

// File: tb/svid_rx_tb_top.sv
module svid_rx_tb_top;
  localparam int Q = 8;
  localparam logic [6:0] BOOT = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [20:0] rail_vid_o;
  logic [2:0]  rail_psi_o, update_o;

  always #4 clk = ~clk;  // 125 MHz

  svid_rx #(.BOOT_VID(BOOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_m & ~sda_oe),
    .sda_oe(sda_oe), .rail_vid_o(rail_vid_o), .rail_psi_o(rail_psi_o),
    .update_o(update_o));

  int total = 0, bad = 0, cyc = 0;
  bit done = 0, mon_on = 0;
  // reference model
  logic [6:0] ev [3];
  logic [2:0] ep;
  bit pend = 0;
  logic [2:0] pm, cm_mask;
  logic [7:0] pd, cm_data;
  int commit_cyc = -1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (mon_on) begin
    logic [2:0] eu;
    if (cyc == commit_cyc)
      for (int i = 0; i < 3; i++) if (cm_mask[i]) begin ev[i] = cm_data[6:0]; ep[i] = cm_data[7]; end
    eu = (cyc == commit_cyc) ? cm_mask : 3'b000;
    chk(rail_vid_o == {ev[2], ev[1], ev[0]}, "R6 R7 R8 R9 rail_vid", 32'(rail_vid_o), 32'({ev[2], ev[1], ev[0]}));
    chk(rail_psi_o == ep, "R7 R8 R9 rail_psi", 32'(rail_psi_o), 32'(ep));
    chk(update_o == eu, "R6 R8 R9 update", 32'(update_o), 32'(eu));
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
    pend = 0;
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; wq(); scl = 1'b1; wq();
    sda_m = 1'b1;
    if (pend) begin commit_cyc = cyc + 3; cm_mask = pm; cm_data = pd; end
    pend = 0;
    wq();
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wq(); scl = 1'b1; wq();
    chk(sda_oe == 1'b0, "R5 oe low in data bit", 32'(sda_oe), 0);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    chk(sda_oe == exp_ack, {tag, " R5 ack before 9th clock"}, 32'(sda_oe), 32'(exp_ack));
    scl = 1'b1; wq();
    chk(sda_oe == exp_ack, {tag, " ack in 9th clock high"}, 32'(sda_oe), 32'(exp_ack));
    scl = 1'b0; wq();
    chk(sda_oe == 1'b0, "R5 ack released", 32'(sda_oe), 0);
  endtask

  task automatic txn(input logic [6:0] addr, input bit rw, input logic [7:0] data, input bit stop);
    bit valid;
    valid = (addr[6:4] == 3'b110) && !rw;
    bus_start();
    send_byte({addr, rw}, valid, "R2 R3 R4 addr");
    send_byte(data, valid, "R7 data");
    if (valid) begin pend = 1; pm = addr[2:0]; pd = data; end
    if (stop) bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) ev[i] = BOOT;
    ep = 3'b111;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rail_vid_o == {3{BOOT}}, "R1 boot vid", 32'(rail_vid_o), 32'({3{BOOT}}));
    chk(rail_psi_o == 3'b111, "R1 psi", 32'(rail_psi_o), 32'h7);
    chk(update_o == 3'b000 && sda_oe == 1'b0, "R1 strobes idle", 32'({update_o, sda_oe}), 0);
    mon_on = 1;
    wq();
    txn(7'b110_0_010, 1'b0, 8'h25, 1'b1);   // R6 core 0, R7 psi 0
    txn(7'b110_1_101, 1'b0, 8'h9A, 1'b1);   // R2 reserved bit set, rails 2 and 0
    txn(7'b110_0_111, 1'b0, 8'h7F, 1'b1);   // R6 all rails
    txn(7'b100_0_111, 1'b0, 8'h11, 1'b1);   // R3 bad prefix
    txn(7'b110_0_111, 1'b1, 8'h22, 1'b1);   // R4 read flag
    txn(7'b110_0_000, 1'b0, 8'h33, 1'b1);   // R6 no rail selected
    // R9 stop in the middle of the data byte
    bus_start();
    send_byte({7'b110_0_001, 1'b0}, 1'b1, "R9 addr");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    // R9 start in the middle of the data byte, then a full command
    bus_start();
    send_byte({7'b110_0_100, 1'b0}, 1'b1, "R9 addr");
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    txn(7'b110_0_001, 1'b0, 8'h85, 1'b1);
    // R9 repeated start after data ack discards pending values
    txn(7'b110_0_110, 1'b0, 8'h44, 1'b0);
    txn(7'b110_0_001, 1'b0, 8'h06, 1'b1);
    repeat (20) @(negedge clk);
    chk(rail_vid_o == {7'h7F, 7'h7F, 7'h06}, "R9 final rails", 32'(rail_vid_o), 32'({7'h7F, 7'h7F, 7'h06}));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired R1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule